// File: doc/BRIEF.md
# Atomic-Update GPIO Data Port

This block is a 32-pin general-purpose port that sits behind a small word-wide register bus. The bus has an address, a write strobe, write data and a registered read path. One output data register drives the pins directly. Software may overwrite that register, or it may change selected bits without a read-modify-write sequence. To do so it writes a mask to one of three write-only alias offsets, which set, clear or invert only the bits whose mask bit is 1.

The pin inputs pass through a two-flop synchronizer into a read-only input register. Software reads that register to sample the external levels. Offsets that are not decoded return zero and ignore writes. Pin direction, multiplexing, pulls and interrupts belong to neighbouring blocks.

Top module: `gpio_port`

## Requirements
- R1: While reset is high at a clock edge, the output data register and the registered read data are cleared to zero, so `pin_out` is 0 after reset.
- R2: A write to byte offset 0x00 loads the whole write-data word into the output data register at that edge, and a read of 0x00 returns the register contents.
- R3: A write to offset 0x04 sets to 1 every output bit whose write-data bit is 1 and leaves every other bit unchanged.
- R4: A write to offset 0x08 clears to 0 every output bit whose write-data bit is 1 and leaves every other bit unchanged.
- R5: A write to offset 0x0C inverts every output bit whose write-data bit is 1 and leaves every other bit unchanged.
- R6: A read of offset 0x10 returns the pin levels through a two-flop synchronizer. A level present on `pin_in` before edge k is in the input register after edge k+1, and it appears on `bus_rdata` after edge k+2 when offset 0x10 is addressed at that edge.
- R7: Reads of the set, clear and toggle offsets (0x04, 0x08, 0x0C) return zero.
- R8: A write to offset 0x10 has no effect on the output data register.
- R9: Any other offset, including a byte address whose two low bits are not zero, reads as zero, and writes to it leave the output data register unchanged.
- R10: `pin_out` always equals the output data register, and in any cycle without a write strobe it keeps its value.
- R11: `bus_rdata` is registered. The address present at a clock edge selects the value loaded at that edge, and a read coinciding with a write returns the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte offset of the access |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data or bit mask |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output pin drive |

## Verification
On every cycle the assertions check the effect of each kind of write on `pin_out`: the full load, the set, clear and toggle masks, and the no-effect cases for the input offset, unmapped offsets and idle cycles. They also check that the alias and unmapped offsets read as zero and that reset clears the outputs. The bench scenarios alone show the synchronizer latency of the input path with cycle accuracy. They also show read-before-write ordering when a read and a write fall in the same cycle, and that read data and `pin_out` agree after a sequence of mixed updates.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int GP_W  = 32;
    localparam int GP_AW = 5;

    localparam logic [GP_AW-1:0] OFS_DATA = 5'h00;
    localparam logic [GP_AW-1:0] OFS_SET  = 5'h04;
    localparam logic [GP_AW-1:0] OFS_CLR  = 5'h08;
    localparam logic [GP_AW-1:0] OFS_TOG  = 5'h0C;
    localparam logic [GP_AW-1:0] OFS_IN   = 5'h10;

    typedef enum logic [2:0] {
        SEL_DATA = 3'd0,
        SEL_SET  = 3'd1,
        SEL_CLR  = 3'd2,
        SEL_TOG  = 3'd3,
        SEL_IN   = 3'd4,
        SEL_NONE = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic            wr;
        reg_sel_e        sel;
        logic [GP_W-1:0] mask;
    } bus_req_t;

    function automatic reg_sel_e decode_ofs(input logic [GP_AW-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_DATA: s = SEL_DATA;
            OFS_SET:  s = SEL_SET;
            OFS_CLR:  s = SEL_CLR;
            OFS_TOG:  s = SEL_TOG;
            OFS_IN:   s = SEL_IN;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [GP_W-1:0] apply_req(input logic [GP_W-1:0] cur,
                                                  input bus_req_t        req);
        logic [GP_W-1:0] nxt;
        nxt = cur;
        if (req.wr) begin
            case (req.sel)
                SEL_DATA: nxt = req.mask;
                SEL_SET:  nxt = cur | req.mask;
                SEL_CLR:  nxt = cur & ~req.mask;
                SEL_TOG:  nxt = cur ^ req.mask;
                default:  nxt = cur;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/gpio_bus_dec.sv
module gpio_bus_dec
    import gpio_pkg::*;
(
    input  logic [GP_AW-1:0] addr,
    input  logic             we,
    input  logic [GP_W-1:0]  wdata,
    output bus_req_t         req
);
    always_comb begin
        req.wr   = we;
        req.sel  = decode_ofs(addr);
        req.mask = wdata;
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[i] <= '0;
                    else     stage[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[i] <= '0;
                    else     stage[i] <= stage[i-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg
    import gpio_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  bus_req_t        req,
    output logic [GP_W-1:0] data_q
);
    logic [GP_W-1:0] data_d;

    always_comb data_d = apply_req(data_q, req);

    always_ff @(posedge clk) begin
        if (rst) data_q <= '0;
        else     data_q <= data_d;
    end
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
    import gpio_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  reg_sel_e        sel,
    input  logic [GP_W-1:0] data_q,
    input  logic [GP_W-1:0] in_q,
    output logic [GP_W-1:0] rdata
);
    logic [GP_W-1:0] rd_d;

    always_comb begin
        case (sel)
            SEL_DATA: rd_d = data_q;
            SEL_IN:   rd_d = in_q;
            default:  rd_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= rd_d;
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [GP_AW-1:0] bus_addr,
    input  logic             bus_we,
    input  logic [GP_W-1:0]  bus_wdata,
    output logic [GP_W-1:0]  bus_rdata,
    input  logic [GP_W-1:0]  pin_in,
    output logic [GP_W-1:0]  pin_out
);
    bus_req_t        req;
    logic [GP_W-1:0] data_q;
    logic [GP_W-1:0] in_q;

    gpio_bus_dec u_dec (
        .addr  (bus_addr),
        .we    (bus_we),
        .wdata (bus_wdata),
        .req   (req)
    );

    gpio_out_reg u_out (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .data_q (data_q)
    );

    gpio_in_sync #(.W(GP_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (in_q)
    );

    gpio_rd_mux u_rd (
        .clk    (clk),
        .rst    (rst),
        .sel    (req.sel),
        .data_q (data_q),
        .in_q   (in_q),
        .rdata  (bus_rdata)
    );

    assign pin_out = data_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [GP_AW-1:0] bus_addr,
    input logic             bus_we,
    input logic [GP_W-1:0]  bus_wdata,
    input logic [GP_W-1:0]  bus_rdata,
    input logic [GP_W-1:0]  pin_out
);
    logic unmapped;
    assign unmapped = (bus_addr != 5'h00) && (bus_addr != 5'h04) && (bus_addr != 5'h08)
                   && (bus_addr != 5'h0C) && (bus_addr != 5'h10);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (pin_out == '0) && (bus_rdata == '0));

    a_r2_full_load: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 5'h00) |=> pin_out == $past(bus_wdata));

    a_r3_set_mask: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 5'h04) |=> pin_out == ($past(pin_out) | $past(bus_wdata)));

    a_r4_clear_mask: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 5'h08) |=> pin_out == ($past(pin_out) & ~$past(bus_wdata)));

    a_r5_toggle_mask: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 5'h0C) |=> pin_out == ($past(pin_out) ^ $past(bus_wdata)));

    a_r7_alias_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 5'h04 || bus_addr == 5'h08 || bus_addr == 5'h0C) |=> bus_rdata == '0);

    a_r8_input_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 5'h10) |=> $stable(pin_out));

    a_r9_unmapped_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_we && unmapped) |=> $stable(pin_out));

    a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (rst)
        unmapped |=> bus_rdata == '0);

    a_r10_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !bus_we |=> $stable(pin_out));

    a_r11_read_before_write: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 5'h00) |=> bus_rdata == $past(pin_out));
endmodule

bind gpio_port gpio_port_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in;
    logic [31:0] pin_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [31:0] model;

    always #2.5 clk = ~clk;

    gpio_port u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a; bus_we = 1'b0;
        @(posedge clk);
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        check("R1 pin_out after reset", pin_out, 32'h0);
        check("R1 rdata after reset", bus_rdata, 32'h0);
        bus_read(5'h00, r);
        check("R1 data reg reads zero", r, 32'h0);
    endtask

    task automatic t_load();
        logic [31:0] r;
        model = 32'hA5A5_0F0F;
        bus_write(5'h00, model);
        check("R2 load drives pins", pin_out, model);
        bus_read(5'h00, r);
        check("R2 R10 readback equals pins", r, pin_out);
    endtask

    task automatic t_set_clr_tog();
        logic [31:0] r;
        bus_write(5'h04, 32'h0000_00F0); model = model | 32'h0000_00F0;
        check("R3 set mask", pin_out, model);
        bus_write(5'h04, 32'h8000_0001); model = model | 32'h8000_0001;
        check("R3 set top and bottom", pin_out, model);
        bus_write(5'h08, 32'hFF00_000F); model = model & ~32'hFF00_000F;
        check("R4 clear mask", pin_out, model);
        bus_write(5'h08, 32'h0); 
        check("R4 empty clear mask", pin_out, model);
        bus_write(5'h0C, 32'h0F0F_FFFF); model = model ^ 32'h0F0F_FFFF;
        check("R5 toggle mask", pin_out, model);
        bus_write(5'h0C, 32'h0F0F_FFFF); model = model ^ 32'h0F0F_FFFF;
        check("R5 toggle twice restores", pin_out, model);
        bus_read(5'h00, r);
        check("R10 readback after mixed updates", r, model);
    endtask

    task automatic t_alias_reads();
        logic [31:0] r;
        bus_read(5'h04, r); check("R7 set alias reads zero", r, 32'h0);
        bus_read(5'h08, r); check("R7 clear alias reads zero", r, 32'h0);
        bus_read(5'h0C, r); check("R7 toggle alias reads zero", r, 32'h0);
    endtask

    task automatic t_ignored_writes();
        logic [31:0] r;
        bus_write(5'h10, 32'hFFFF_FFFF);
        check("R8 input write ignored", pin_out, model);
        bus_write(5'h14, 32'hFFFF_FFFF);
        check("R9 write 0x14 ignored", pin_out, model);
        bus_write(5'h1C, 32'h1234_5678);
        check("R9 write 0x1C ignored", pin_out, model);
        bus_write(5'h05, 32'hFFFF_FFFF);
        check("R9 misaligned write ignored", pin_out, model);
        bus_read(5'h18, r);
        check("R9 unmapped reads zero", r, 32'h0);
        bus_read(5'h01, r);
        check("R9 misaligned read zero", r, 32'h0);
    endtask

    task automatic t_input_sync();
        logic [31:0] r;
        pin_in = 32'h0;
        repeat (4) @(negedge clk);
        pin_in = 32'h1234_5678;
        bus_read(5'h10, r);
        check("R6 not visible after one edge", r, 32'h0);
        bus_read(5'h10, r);
        check("R6 not visible after two edges", r, 32'h0);
        bus_read(5'h10, r);
        check("R6 visible after three edges", r, 32'h1234_5678);
        pin_in = 32'hFFFF_0000;
        repeat (3) @(negedge clk);
        bus_read(5'h10, r);
        check("R6 second pattern", r, 32'hFFFF_0000);
        check("R6 pins do not touch output", pin_out, model);
    endtask

    task automatic t_read_during_write();
        logic [31:0] r;
        logic [31:0] old;
        old = model;
        model = 32'h5A5A_C3C3;
        bus_write(5'h00, model);
        check("R11 read during write returns old value", bus_rdata, old);
        bus_read(5'h00, r);
        check("R11 next read returns new value", r, model);
    endtask

    initial begin
        rst = 1'b1; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pin_in = 32'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load();
        t_set_clr_tog();
        t_alias_reads();
        t_ignored_writes();
        t_input_sync();
        t_read_during_write();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule